// File: doc/BRIEF.md
# Deep Stop Power Sequencer

This block decides when a small processor subsystem may drop into its deepest low-power state, and it brings the subsystem back out in a controlled order. Software first programs a protected control register. That write only lands when a fixed 16-bit unlock pattern is carried in the same word. Software also clears an RTC-mode enable held in a second register. It then sets its deep-sleep flag and executes a wait-for-interrupt or wait-for-event.

When the block accepts such a request, it turns off the CPU, AHB, APB and debug clock enables and all oscillator enables. Only the low-voltage-detect enable stays asserted. The pins are either frozen at their last value or put into high impedance, as one control bit selects. Because the clocks stop instead of the logic resetting, peripheral and memory state is preserved.

An interrupt starts the wake sequence on the always-running wake clock `clk`. The oscillators start first. The block then waits a programmable number of settling cycles, enables the bus clocks, and enables the CPU clock one cycle after that. A reset during stop returns everything to its defaults.

The sequencer has four states:
- RUN: normal operation.
- STOP: all gated.
- WARM: oscillators on and settling.
- BUS: bus clocks on, CPU still held.

The transitions are:
- RUN→STOP on an accepted request.
- STOP→WARM on an interrupt.
- WARM→BUS when the settling count expires.
- BUS→RUN after one cycle.
- Any state→RUN on reset.

Top module: `stopctl_top`

## Requirements
- R1: A write to the control register (reg_addr=0) updates its fields only when reg_wdata[31:16] equals 16'h1ACC; any other write leaves every field unchanged.
- R2: Reading the control register returns mode in bits [1:0], the timer-keep bit in bit 2, the pin-float bit in bit 4, the sticky reject flag in bit 7, the settle count in bits [15:8], and zero in bits [31:16] and all other bits. Reset values are mode=00, timer-keep=0, float=0, reject=0, settle=4.
- R3: The RTC-mode register (reg_addr=1) stores bit 0 of any write without a key and reads back in bit 0, with the other bits reading zero.
- R4: In RUN, a request (sleep_deep=1 with wfi_req or wfe_req) is accepted when mode=2'b10, timer-keep=0 and RTC-mode=0; in_stop is then 1 from the next cycle.
- R5: A request with sleep_deep=1 whose preconditions fail leaves the block in RUN and sets the reject flag. The flag stays set until the next keyed control write clears it. A request with sleep_deep=0 does nothing.
- R6: While in_stop=1, cpu_clk_en, ahb_clk_en, apb_clk_en, dbg_clk_en and osc_en are 0, and lvd_en is 1.
- R7: Outside RUN, float=0 gives pin_hold=1 and pin_hiz=0, and float=1 gives pin_hiz=1 and pin_hold=0. In RUN, both are 0.
- R8: An interrupt in STOP raises osc_en in the next cycle. The AHB and APB enables rise after max(settle,1) further cycles, and cpu_clk_en rises exactly one cycle after them.
- R9: An interrupt wake keeps all register contents. A reset in any state returns the registers to their defaults and clears pin hold.
- R10: Register writes and new requests made outside RUN are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running wake clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = RTC-mode register |
| reg_wdata | input | 32 | Write data (unlock key in [31:16]) |
| reg_rdata | output | 32 | Read data for reg_addr |
| sleep_deep | input | 1 | CPU deep-sleep flag |
| wfi_req | input | 1 | Wait-for-interrupt request |
| wfe_req | input | 1 | Wait-for-event request |
| wake_irq | input | 1 | Wake interrupt |
| cpu_clk_en | output | 1 | CPU clock enable |
| ahb_clk_en | output | 1 | AHB (memory/DMA) clock enable |
| apb_clk_en | output | 1 | APB peripheral clock enable |
| dbg_clk_en | output | 1 | Debug clock enable |
| osc_en | output | 1 | Oscillator enables |
| lvd_en | output | 1 | Low-voltage-detect enable |
| pin_hold | output | 1 | Freeze pins at last value |
| pin_hiz | output | 1 | Force pin output enables off |
| in_stop | output | 1 | Block is in STOP |

## Verification
The embedded assertions check the following on every cycle:
- A rejected control write leaves the fields unchanged.
- Every RUN→STOP transition had its preconditions met, and every reject follows a failing request.
- BUS is reached only from WARM.
- STOP has all clock and oscillator enables low.
- Pin hold and high impedance are never both asserted.
- The CPU clock rises only after the bus clocks were already up.

The exact settling length for each programmed count, the zero-count case, and the field layout on readback can only be shown by the bench's scenarios. The same holds for retention across an interrupt wake versus clearing by reset, and for writes made during stop being dropped.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WARM = 2'd2,
        ST_BUS  = 2'd3
    } pm_state_t;

    localparam logic [15:0] UNLOCK_KEY = 16'h1ACC;
    localparam logic [1:0]  MODE_STOP  = 2'b10;

    // control register bit positions
    localparam int F_MODE   = 0;
    localparam int F_TKEEP  = 2;
    localparam int F_FLOAT  = 4;
    localparam int F_REJECT = 7;
    localparam int F_SETTLE = 8;
    localparam int F_KEY    = 16;

endpackage

// File: rtl/stopctl_regs.sv
module stopctl_regs
    import stopctl_pkg::*;
#(
    parameter int DW     = 32,
    parameter int STAB_W = 8,
    parameter logic [STAB_W-1:0] STAB_DEF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    input  logic              allow,
    input  logic              reject_set,
    output logic [DW-1:0]     rdata,
    output logic [1:0]        mode,
    output logic              tkeep,
    output logic              pin_float,
    output logic [STAB_W-1:0] settle,
    output logic              rtc_en,
    output logic              reject
);

    logic key_ok;
    logic ctl_wr;
    logic rtc_wr;

    assign key_ok = (wdata[F_KEY +: 16] == UNLOCK_KEY);
    assign ctl_wr = allow && wr_en && !addr && key_ok;
    assign rtc_wr = allow && wr_en && addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode      <= 2'b00;
            tkeep     <= 1'b0;
            pin_float <= 1'b0;
            settle    <= STAB_DEF;
            rtc_en    <= 1'b0;
            reject    <= 1'b0;
        end else begin
            if (ctl_wr) begin
                mode      <= wdata[F_MODE +: 2];
                tkeep     <= wdata[F_TKEEP];
                pin_float <= wdata[F_FLOAT];
                settle    <= wdata[F_SETTLE +: STAB_W];
                reject    <= 1'b0;
            end
            if (rtc_wr) begin
                rtc_en <= wdata[0];
            end
            if (reject_set) begin
                reject <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata[0] = rtc_en;
        end else begin
            rdata[F_MODE +: 2]      = mode;
            rdata[F_TKEEP]          = tkeep;
            rdata[F_FLOAT]          = pin_float;
            rdata[F_REJECT]         = reject;
            rdata[F_SETTLE +: STAB_W] = settle;
        end
    end

    // R1
    key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && !key_ok) |=> ($stable(mode) && $stable(tkeep)
                                         && $stable(pin_float) && $stable(settle)));

endmodule

// File: rtl/stopctl_fsm.sv
module stopctl_fsm
    import stopctl_pkg::*;
#(
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_deep,
    input  logic              wfi_req,
    input  logic              wfe_req,
    input  logic              wake_irq,
    input  logic [1:0]        mode,
    input  logic              tkeep,
    input  logic              rtc_en,
    input  logic [STAB_W-1:0] settle,
    output pm_state_t         state,
    output logic              reject_set,
    output logic              cpu_clk_en,
    output logic              ahb_clk_en,
    output logic              apb_clk_en,
    output logic              dbg_clk_en,
    output logic              osc_en
);

    pm_state_t       nxt;
    logic            req;
    logic            entry_ok;
    logic            settled;
    logic [STAB_W:0] cnt;

    assign req      = (state == ST_RUN) && sleep_deep && (wfi_req || wfe_req);
    assign entry_ok = (mode == MODE_STOP) && !tkeep && !rtc_en;
    assign settled  = ((cnt + 1'b1) >= {1'b0, settle});
    assign reject_set = req && !entry_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= nxt;
        end
    end

    // settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_WARM && !settled) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (req && entry_ok) nxt = ST_STOP;
            ST_STOP: if (wake_irq)        nxt = ST_WARM;
            ST_WARM: if (settled)         nxt = ST_BUS;
            ST_BUS:                       nxt = ST_RUN;
        endcase
    end

    // output process
    always_comb begin
        cpu_clk_en = 1'b0;
        ahb_clk_en = 1'b0;
        apb_clk_en = 1'b0;
        dbg_clk_en = 1'b0;
        osc_en     = 1'b0;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                ahb_clk_en = 1'b1;
                apb_clk_en = 1'b1;
                dbg_clk_en = 1'b1;
                osc_en     = 1'b1;
            end
            ST_STOP: ;
            ST_WARM: osc_en = 1'b1;
            ST_BUS: begin
                osc_en     = 1'b1;
                ahb_clk_en = 1'b1;
                apb_clk_en = 1'b1;
            end
        endcase
    end

    // R4
    entry_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && $past(state) == ST_RUN) |-> $past(entry_ok && sleep_deep));

    // R5
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject_set |=> (state == ST_RUN));

    // R8
    bus_after_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS) |-> ($past(state) == ST_WARM));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wake_irq) |=> (state == ST_STOP));

endmodule

// File: rtl/stopctl_pins.sv
module stopctl_pins
    import stopctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_t state,
    input  logic      pin_float,
    output logic      pin_hold,
    output logic      pin_hiz
);

    logic parked;

    assign parked = (state != ST_RUN);

    always_comb begin
        pin_hold = 1'b0;
        pin_hiz  = 1'b0;
        if (parked) begin
            if (pin_float) pin_hiz  = 1'b1;
            else           pin_hold = 1'b1;
        end
    end

    // R7
    pin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_hold && pin_hiz));

    // R7
    pin_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (!pin_hold && !pin_hiz));

endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
    import stopctl_pkg::*;
#(
    parameter int DW     = 32,
    parameter int STAB_W = 8,
    parameter logic [STAB_W-1:0] STAB_DEF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sleep_deep,
    input  logic          wfi_req,
    input  logic          wfe_req,
    input  logic          wake_irq,
    output logic          cpu_clk_en,
    output logic          ahb_clk_en,
    output logic          apb_clk_en,
    output logic          dbg_clk_en,
    output logic          osc_en,
    output logic          lvd_en,
    output logic          pin_hold,
    output logic          pin_hiz,
    output logic          in_stop
);

    pm_state_t         state;
    logic [1:0]        mode;
    logic              tkeep;
    logic              pin_float;
    logic [STAB_W-1:0] settle;
    logic              rtc_en;
    logic              reject;
    logic              reject_set;
    logic              unused_reject;

    assign unused_reject = reject;

    stopctl_regs #(.DW(DW), .STAB_W(STAB_W), .STAB_DEF(STAB_DEF)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .allow      (state == ST_RUN),
        .reject_set (reject_set),
        .rdata      (reg_rdata),
        .mode       (mode),
        .tkeep      (tkeep),
        .pin_float  (pin_float),
        .settle     (settle),
        .rtc_en     (rtc_en),
        .reject     (reject)
    );

    stopctl_fsm #(.STAB_W(STAB_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_deep (sleep_deep),
        .wfi_req    (wfi_req),
        .wfe_req    (wfe_req),
        .wake_irq   (wake_irq),
        .mode       (mode),
        .tkeep      (tkeep),
        .rtc_en     (rtc_en),
        .settle     (settle),
        .state      (state),
        .reject_set (reject_set),
        .cpu_clk_en (cpu_clk_en),
        .ahb_clk_en (ahb_clk_en),
        .apb_clk_en (apb_clk_en),
        .dbg_clk_en (dbg_clk_en),
        .osc_en     (osc_en)
    );

    stopctl_pins u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .pin_float (pin_float),
        .pin_hold  (pin_hold),
        .pin_hiz   (pin_hiz)
    );

    assign in_stop = (state == ST_STOP);
    assign lvd_en  = 1'b1;

    // R6
    stop_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop |-> (!cpu_clk_en && !ahb_clk_en && !apb_clk_en && !dbg_clk_en && !osc_en && lvd_en));

    // R8
    cpu_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> ($past(ahb_clk_en) && $past(apb_clk_en) && $past(osc_en)));

    // R8
    osc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ahb_clk_en) |-> $past(osc_en));

endmodule

// File: tb/test_stopctl_top.sv
module test_stopctl_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sleep_deep = 1'b0, wfi_req = 1'b0, wfe_req = 1'b0, wake_irq = 1'b0;
    logic        cpu_clk_en, ahb_clk_en, apb_clk_en, dbg_clk_en, osc_en, lvd_en;
    logic        pin_hold, pin_hiz, in_stop;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model of register contents
    logic [1:0] m_mode;
    logic       m_tkeep, m_float, m_rtc, m_rej;
    logic [7:0] m_settle;

    always #4 clk = ~clk;

    stopctl_top i_stopctl_top (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctl();
        logic [31:0] v = '0;
        v[1:0]  = m_mode;
        v[2]    = m_tkeep;
        v[4]    = m_float;
        v[7]    = m_rej;
        v[15:8] = m_settle;
        return v;
    endfunction

    function automatic logic exp_ok();
        return (m_mode == 2'b10) && !m_tkeep && !m_rtc;
    endfunction

    function automatic int eff_settle();
        return (m_settle == 0) ? 1 : int'(m_settle);
    endfunction

    task automatic model_reset();
        m_mode = 2'b00; m_tkeep = 0; m_float = 0; m_rtc = 0; m_rej = 0; m_settle = 8'd4;
    endtask

    task automatic wr(input logic a, input logic [31:0] d, input bit in_run);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        if (in_run) begin
            if (!a && d[31:16] == 16'h1ACC) begin
                m_mode = d[1:0]; m_tkeep = d[2]; m_float = d[4]; m_settle = d[15:8]; m_rej = 0;
            end
            if (a) m_rtc = d[0];
        end
    endtask

    task automatic readback(input string tag);
        reg_addr = 1'b0; #1;
        chk({tag, " R2 ctl readback"}, reg_rdata, exp_ctl());
        reg_addr = 1'b1; #1;
        chk({tag, " R3 rtc readback"}, reg_rdata, {31'd0, m_rtc});
        reg_addr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic check_gated();
        chk("R6 in_stop", in_stop, 1);
        chk("R6 clocks off", {cpu_clk_en, ahb_clk_en, apb_clk_en, dbg_clk_en, osc_en}, 0);
        chk("R6 lvd on", lvd_en, 1);
        chk("R7 pins", {pin_hold, pin_hiz}, m_float ? 2'b01 : 2'b10);
    endtask

    // request; returns 1 if stop entered
    task automatic request(input bit sd, input bit use_wfe, output bit entered);
        bit exp_enter;
        exp_enter = sd && exp_ok();
        @(negedge clk);
        sleep_deep = sd; wfi_req = !use_wfe; wfe_req = use_wfe;
        @(negedge clk);
        wfi_req = 0; wfe_req = 0; sleep_deep = 0;
        if (sd && !exp_enter) m_rej = 1;
        chk("R4 entry decision", in_stop, exp_enter);
        if (!exp_enter) begin
            chk("R5 stays run", cpu_clk_en, 1);
            readback("R5");
        end
        entered = in_stop;
    endtask

    task automatic wake();
        int s;
        s = eff_settle();
        @(negedge clk);
        wake_irq = 1;
        @(posedge clk);
        @(negedge clk);
        wake_irq = 0;
        chk("R8 osc first", {osc_en, ahb_clk_en, cpu_clk_en}, 3'b100);
        chk("R7 pins held in warm", {pin_hold, pin_hiz}, m_float ? 2'b01 : 2'b10);
        for (int i = 1; i <= s; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i < s) chk("R8 bus still off", {ahb_clk_en, apb_clk_en}, 2'b00);
            else       chk("R8 bus on, cpu off", {ahb_clk_en, apb_clk_en, cpu_clk_en}, 3'b110);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R8 cpu on", {cpu_clk_en, dbg_clk_en, pin_hold, pin_hiz}, 4'b1100);
    endtask

    initial begin
        bit entered;
        void'($urandom(32'd20251));
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R9 reset clocks on", {cpu_clk_en, ahb_clk_en, apb_clk_en, osc_en, lvd_en, in_stop}, 6'b111110);
        chk("R7 reset pins", {pin_hold, pin_hiz}, 2'b00);
        readback("R9 reset");
        // R1: wrong key ignored
        wr(0, {16'h1ACD, 8'h02, 8'h12}, 1);
        readback("R1 bad key");
        // R2: key reads zero
        wr(0, {16'h1ACC, 8'h00, 8'h02}, 1);
        readback("R2 key zero");
        // R8 zero settle: treated as one cycle; R7 hold variant
        request(1, 0, entered);
        check_gated();
        // R10: write during stop ignored, new request ignored
        wr(0, {16'h1ACC, 8'h05, 8'h13}, 0);
        wr(1, 32'h1, 0);
        chk("R10 still stopped", in_stop, 1);
        wake();
        readback("R9 R10 after irq wake");
        // R5: sleep_deep=0 does nothing, rtc set rejects
        request(0, 0, entered);
        wr(1, 32'h1, 1);
        request(1, 1, entered);
        wr(1, 32'h0, 1);
        readback("R5 sticky");
        // R9: reset during stop with float
        wr(0, {16'h1ACC, 8'h03, 8'h12}, 1);
        request(1, 1, entered);
        check_gated();
        do_reset();
        chk("R9 reset in stop", {in_stop, pin_hold, pin_hiz, cpu_clk_en}, 4'b0001);
        readback("R9 after reset");
        // constrained random
        for (int it = 0; it < 60; it++) begin
            logic [31:0] d;
            bit badkey;
            badkey = ($urandom % 6) == 0;
            d = '0;
            d[1:0]  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b10;
            d[2]    = ($urandom % 5) == 0;
            d[4]    = $urandom % 2;
            d[15:8] = 8'($urandom % 7);
            d[31:16] = badkey ? 16'($urandom) | 16'h0001 ^ 16'h1ACC : 16'h1ACC;
            if (badkey && d[31:16] == 16'h1ACC) d[31:16] = 16'h0000;
            wr(0, d, 1);
            wr(1, {31'd0, ($urandom % 5) == 0}, 1);
            readback("R1 R3 random");
            request(($urandom % 8) != 0, $urandom % 2, entered);
            if (entered) begin
                check_gated();
                repeat ($urandom % 4) @(negedge clk);
                if (($urandom % 6) == 0) begin
                    do_reset();
                    chk("R9 random reset", {in_stop, pin_hold, pin_hiz}, 3'b000);
                    readback("R9 random reset");
                end else begin
                    wake();
                    readback("R9 random wake");
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule